// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frame data from memory to a byte stream under the control of a ring of 8-byte transmit descriptors. Software fills in a descriptor, sets its ready flag, and then writes the activate register. The engine then reads descriptors one after another, starting at its current descriptor pointer. For each ready descriptor it fetches the data buffer one byte at a time and passes the bytes to the stream output. It then writes the descriptor back with the ready flag cleared, which returns the descriptor to software. It moves on to the next descriptor and stops when it finds one that is not ready.

A frame can span several descriptors. A flag in the descriptor marks the last buffer of a frame. After that buffer the engine sends a separate end-of-frame beat on the stream. One register selects the ring base. A per-descriptor wrap flag sends the pointer back to that base. A frame-size budget drops bytes beyond a parameterised maximum and reports the overflow. Three single-cycle event pulses go to the interrupt controller: descriptor done, frame done and transmit babble.

The sequencer has seven states:
- IDLE: waits for an activate write.
- HDR: reads the flags and length word.
- PTR: reads the buffer address word.
- DATA: reads the memory word that holds the next byte.
- BYTE: offers that byte on the stream.
- EOF: offers the end-of-frame beat.
- WB: writes the descriptor back.

The transitions are:
- IDLE→HDR: activate written while enabled.
- HDR→IDLE: descriptor not ready.
- HDR→PTR: descriptor ready.
- PTR→DATA: bytes left to send.
- PTR→EOF: nothing to send on a last descriptor.
- PTR→WB: nothing to send on a middle descriptor.
- DATA→BYTE: word arrived.
- BYTE→DATA: more bytes to send.
- BYTE→EOF: final byte of a last descriptor.
- BYTE→WB: final byte of a middle descriptor.
- EOF→WB: end-of-frame beat accepted.
- WB→HDR: write accepted; the pointer advances.

Top module: `txbd_ring_engine`

## Requirements
- R1: During and straight after reset the engine makes no memory request, offers no stream beat, pulses no event, and the ring base register reads 0.
- R2: Writing register address 0 stores the written value with bits 1:0 forced to 0, reads back as that value, and moves the current descriptor pointer to it.
- R3: Register address 1 (activate) always reads as 0. A write to it starts the engine only when `ctrl_en` is 1. With `ctrl_en` at 0 the write causes no memory request.
- R4: A descriptor consists of two memory words. The word at the descriptor address holds the flags in bits 31:16 and the byte length in bits 15:0. The word at address+4 holds the buffer byte address. Flags bit 15 is ready. If the ready flag is clear, the engine stops without any write, byte or event.
- R5: The buffer bytes of a ready descriptor appear on the stream in ascending address order. Within a memory word, the byte at the lowest address is bits 31:24. The buffers of consecutive descriptors are concatenated. After the descriptor with flags bit 11 (last) set, one beat with `tx_eof`=1 follows.
- R6: After a descriptor is used, the engine writes the header word back to the descriptor address with bit 31 (ready) cleared and every other bit unchanged, including the original length.
- R7: `ev_txb` pulses once for each written-back descriptor. `ev_txf` pulses in the same cycle when that descriptor has the last flag set.
- R8: After write-back, the pointer goes to the ring base if flags bit 13 (wrap) is set, and otherwise to the descriptor address plus 8.
- R9: At most MAX_FRAME bytes of a frame are sent and the rest are dropped. `ev_babt` pulses at the write-back of each descriptor whose data was cut short. The byte count starts again at 0 after each end-of-frame beat.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, the beat (`tx_data`, `tx_eof`) stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = ring base, 1 = activate |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes in a cycle with mem_req and mem_ack both high |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Stream beat offered |
| tx_data | output | 8 | Stream byte |
| tx_eof | output | 1 | Beat is an end-of-frame marker that carries no byte |
| tx_ready | input | 1 | Sink accepts the beat |
| ev_txb | output | 1 | Descriptor-done pulse |
| ev_txf | output | 1 | Frame-done pulse |
| ev_babt | output | 1 | Frame-overflow pulse |

## Verification
The assertions rely on the memory side acknowledging only while a request is raised. They also rely on the ring base not being rewritten while an access is held, because such a write would move a pending address. The bench's memory model acknowledges a raised request in the next cycle and then leaves one idle cycle. It writes the ring base only while the engine is idle. All descriptor and data addresses stay inside a 1 KiB model. Back-pressure on the stream comes from a fixed ready pattern. A separate monitor checks that any stalled beat stays unchanged.

// File: rtl/txr_pkg.sv
package txr_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_PTR, S_DATA, S_BYTE, S_EOF, S_WB
    } txr_state_e;

    localparam int FLG_READY = 15;
    localparam int FLG_WRAP  = 13;
    localparam int FLG_LAST  = 11;
    localparam int DESC_STEP = 8;
endpackage

// File: rtl/txr_ptr_regs.sv
module txr_ptr_regs #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr,
    input  logic [AW-1:0] base_wdata,
    input  logic          step,
    input  logic          wrap,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] cur_q
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);
    localparam logic [AW-1:0] STEP_VAL = AW'(txr_pkg::DESC_STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (base_wr) begin
            base_q <= base_wdata & ALIGN_MASK;
            cur_q  <= base_wdata & ALIGN_MASK;
        end else if (step) begin
            cur_q <= wrap ? base_q : cur_q + STEP_VAL;
        end
    end

    AST_BASE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> (base_q == ($past(base_wdata) & ALIGN_MASK)) && (cur_q == base_q)); // R2
    AST_PTR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q[1:0] == 2'b00); // R8
endmodule

// File: rtl/txr_frame_budget.sv
module txr_frame_budget #(
    parameter int MAX_FRAME = 2032
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] want_len,
    input  logic        byte_sent,
    input  logic        frame_done,
    output logic [15:0] grant_len,
    output logic        over
);
    localparam int CW = $clog2(MAX_FRAME + 1);
    localparam logic [15:0] MAX16 = 16'(MAX_FRAME);

    logic [CW-1:0] count_q;
    logic [15:0]   room;

    assign room      = MAX16 - {{(16-CW){1'b0}}, count_q};
    assign over      = want_len > room;
    assign grant_len = over ? room : want_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          count_q <= '0;
        else if (frame_done) count_q <= '0;
        else if (byte_sent)  count_q <= count_q + CW'(1);
    end

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        {{(16-CW){1'b0}}, count_q} <= MAX16); // R9
endmodule

// File: rtl/txr_lane_sel.sv
module txr_lane_sel (
    input  logic [31:0] word,
    input  logic [1:0]  lane,
    output logic [7:0]  byte_out
);
    logic [7:0] lanes [4];

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign lanes[g] = word[31-8*g -: 8];
    end

    assign byte_out = lanes[lane];
endmodule

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine #(
    parameter int MAX_FRAME = 2032
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_en,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_eof,
    input  logic        tx_ready,
    output logic        ev_txb,
    output logic        ev_txf,
    output logic        ev_babt
);
    import txr_pkg::*;

    txr_state_e state_q, state_d;
    logic [15:0] flags_q, len_q, remain_q;
    logic [31:0] bufp_q, base_q, cur_q;
    logic [7:0]  byte_q, lane_byte;
    logic [15:0] grant_len;
    logic        over, over_q;
    logic        base_wr, act_hit, step, is_last;

    assign base_wr = reg_wr && (reg_addr == 1'b0);
    assign act_hit = reg_wr && (reg_addr == 1'b1) && ctrl_en;
    assign is_last = flags_q[FLG_LAST];
    assign step    = (state_q == S_WB) && mem_ack;
    assign reg_rdata = (reg_addr == 1'b0) ? base_q : 32'd0;

    txr_ptr_regs #(.AW(32)) u_ptr (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(reg_wdata),
        .step(step), .wrap(flags_q[FLG_WRAP]), .base_q(base_q), .cur_q(cur_q)
    );

    txr_frame_budget #(.MAX_FRAME(MAX_FRAME)) u_budget (
        .clk(clk), .rst_n(rst_n), .want_len(len_q),
        .byte_sent((state_q == S_BYTE) && tx_ready),
        .frame_done((state_q == S_EOF) && tx_ready),
        .grant_len(grant_len), .over(over)
    );

    txr_lane_sel u_lane (.word(mem_rdata), .lane(bufp_q[1:0]), .byte_out(lane_byte));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (act_hit) state_d = S_HDR;
            S_HDR:  if (mem_ack) state_d = mem_rdata[16+FLG_READY] ? S_PTR : S_IDLE;
            S_PTR:  if (mem_ack) begin
                        if (grant_len != 16'd0) state_d = S_DATA;
                        else                    state_d = is_last ? S_EOF : S_WB;
                    end
            S_DATA: if (mem_ack) state_d = S_BYTE;
            S_BYTE: if (tx_ready) begin
                        if (remain_q != 16'd1) state_d = S_DATA;
                        else                   state_d = is_last ? S_EOF : S_WB;
                    end
            S_EOF:  if (tx_ready) state_d = S_WB;
            S_WB:   if (mem_ack) state_d = S_HDR;
            default: state_d = S_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            flags_q  <= '0;
            len_q    <= '0;
            remain_q <= '0;
            bufp_q   <= '0;
            byte_q   <= '0;
            over_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_HDR && mem_ack) begin
                flags_q <= mem_rdata[31:16];
                len_q   <= mem_rdata[15:0];
            end
            if (state_q == S_PTR && mem_ack) begin
                bufp_q   <= mem_rdata;
                remain_q <= grant_len;
                over_q   <= over;
            end
            if (state_q == S_DATA && mem_ack) byte_q <= lane_byte;
            if (state_q == S_BYTE && tx_ready) begin
                bufp_q   <= bufp_q + 32'd1;
                remain_q <= remain_q - 16'd1;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = {flags_q & ~(16'd1 << FLG_READY), len_q};
        tx_valid  = 1'b0;
        tx_eof    = 1'b0;
        tx_data   = byte_q;
        ev_txb    = 1'b0;
        ev_txf    = 1'b0;
        ev_babt   = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_HDR:  mem_req = 1'b1;
            S_PTR:  begin mem_req = 1'b1; mem_addr = cur_q + 32'd4; end
            S_DATA: begin mem_req = 1'b1; mem_addr = {bufp_q[31:2], 2'b00}; end
            S_BYTE: tx_valid = 1'b1;
            S_EOF:  begin tx_valid = 1'b1; tx_eof = 1'b1; end
            S_WB:   begin
                        mem_req = 1'b1;
                        mem_we  = 1'b1;
                        ev_txb  = mem_ack;
                        ev_txf  = mem_ack && is_last;
                        ev_babt = mem_ack && over_q;
                    end
            default: ;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R4
    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_eof)); // R10
    AST_FRAME_EV: assert property (@(posedge clk) disable iff (!rst_n)
        ev_txf |-> ev_txb); // R7
    AST_BABT_EV: assert property (@(posedge clk) disable iff (!rst_n)
        ev_babt |-> ev_txb); // R9
    AST_WB_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[16+FLG_READY]); // R6
endmodule

// File: tb/txbd_ring_engine_test.sv
module txbd_ring_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXF = 16;

    logic clk = 1'b0, rst_n = 1'b0, ctrl_en = 1'b0;
    logic reg_wr = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic tx_valid, tx_eof, tx_ready = 1'b1;
    logic [7:0] tx_data;
    logic ev_txb, ev_txf, ev_babt;

    int checks = 0, errors = 0;
    logic [31:0] mem [256];
    logic [8:0] got [64];
    logic [8:0] exp_s [64];
    int n_got = 0, n_exp = 0, n_txb = 0, n_txf = 0, n_babt = 0;
    int n_req = 0, n_wr = 0, stall_bad = 0, cyc = 0;
    logic bp_on = 1'b0, prev_stall = 1'b0, prev_eof = 1'b0;
    logic [7:0] prev_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txbd_ring_engine #(.MAX_FRAME(MAXF)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_eof(tx_eof),
        .tx_ready(tx_ready), .ev_txb(ev_txb), .ev_txf(ev_txf), .ev_babt(ev_babt)
    );

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model, stream sink and event monitor
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            tx_ready = bp_on ? (cyc % 3 != 0) : 1'b1;
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req && rst_n) begin
                mem_ack = 1'b1;
                n_req++;
                if (mem_we) begin
                    mem[mem_addr[9:2]] = mem_wdata;
                    n_wr++;
                end else mem_rdata = mem[mem_addr[9:2]];
            end
            #1;
            if (prev_stall && !(tx_valid && tx_data == prev_data && tx_eof == prev_eof))
                stall_bad++;
            prev_stall = tx_valid && !tx_ready;
            prev_data = tx_data;
            prev_eof = tx_eof;
            if (tx_valid && tx_ready && n_got < 64) begin
                got[n_got] = tx_eof ? 9'h100 : {1'b0, tx_data};
                n_got++;
            end
            if (ev_txb) n_txb++;
            if (ev_txf) n_txf++;
            if (ev_babt) n_babt++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic reg_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_logs();
        n_got = 0; n_exp = 0; n_txb = 0; n_txf = 0; n_babt = 0; n_wr = 0; n_req = 0;
    endtask

    task automatic add_exp(input logic [31:0] a, input int len);
        for (int i = 0; i < len; i++) begin
            exp_s[n_exp] = {1'b0, pat(a + 32'(i))};
            n_exp++;
        end
    endtask

    task automatic add_eof();
        exp_s[n_exp] = 9'h100;
        n_exp++;
    endtask

    task automatic set_desc(input logic [31:0] a, input logic [15:0] fl,
                            input logic [15:0] len, input logic [31:0] buf_a);
        mem[a[9:2]] = {fl, len};
        mem[a[9:2] + 8'd1] = buf_a;
    endtask

    task automatic run_and_compare(input string tag);
        int bad;
        reg_write(1'b1, 32'd0);
        repeat (400) @(negedge clk);
        chk(32'(n_got), 32'(n_exp), {tag, " stream length"});
        bad = 0;
        for (int i = 0; i < n_exp && i < n_got; i++)
            if (got[i] !== exp_s[i]) bad++;
        chk(32'(bad), 32'd0, {tag, " stream content mismatches"});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        #1;
        chk({31'd0, mem_req}, 32'd0, "R1 mem_req in reset");
        chk({31'd0, tx_valid}, 32'd0, "R1 tx_valid in reset");
        chk({29'd0, ev_txb, ev_txf, ev_babt}, 32'd0, "R1 events in reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reg_read(1'b0, d);
        chk(d, 32'd0, "R1 base after reset");
        repeat (3) @(negedge clk);
        chk(32'(n_req), 32'd0, "R1 no request after reset");
    endtask

    task automatic t_regs();
        logic [31:0] d;
        reg_write(1'b0, 32'h0000_0103);
        reg_read(1'b0, d);
        chk(d, 32'h0000_0100, "R2 base low bits cleared");
        reg_read(1'b1, d);
        chk(d, 32'd0, "R3 activate reads zero");
        set_desc(32'h100, 16'h8800, 16'd1, 32'h200);
        clear_logs();
        ctrl_en = 1'b0;
        reg_write(1'b1, 32'd0);
        repeat (20) @(negedge clk);
        chk(32'(n_req), 32'd0, "R3 activate ignored while disabled");
        ctrl_en = 1'b1;
    endtask

    task automatic t_single();
        set_desc(32'h100, 16'h8800, 16'd5, 32'h202);
        set_desc(32'h108, 16'h0000, 16'd0, 32'h0);
        clear_logs();
        add_exp(32'h202, 5); add_eof();
        run_and_compare("R5 single unaligned buffer");
        chk(mem[32'h100 >> 2], 32'h0800_0005, "R6 writeback clears ready keeps length");
        chk(32'(n_txb), 32'd1, "R7 one descriptor event");
        chk(32'(n_txf), 32'd1, "R7 one frame event");
        chk(32'(n_wr), 32'd1, "R4 stop at non-ready without write");
    endtask

    task automatic t_multi_bp();
        bp_on = 1'b1;
        set_desc(32'h108, 16'h8000, 16'd3, 32'h300);
        set_desc(32'h110, 16'hA800, 16'd2, 32'h311);
        clear_logs();
        add_exp(32'h300, 3); add_exp(32'h311, 2); add_eof();
        run_and_compare("R5 two-buffer frame with backpressure");
        chk(32'(stall_bad), 32'd0, "R10 stalled beat unchanged");
        chk(mem[32'h108 >> 2], 32'h0000_0003, "R6 writeback first descriptor");
        chk(mem[32'h110 >> 2], 32'h2800_0002, "R6 writeback wrap descriptor");
        chk(32'(n_txb), 32'd2, "R7 two descriptor events");
        chk(32'(n_txf), 32'd1, "R7 one frame event for two buffers");
        bp_on = 1'b0;
        set_desc(32'h100, 16'h8800, 16'd1, 32'h320);
        clear_logs();
        add_exp(32'h320, 1); add_eof();
        run_and_compare("R8 wrap returns to base");
    endtask

    task automatic t_not_ready();
        reg_write(1'b0, 32'h180);
        set_desc(32'h180, 16'h0800, 16'd4, 32'h200);
        set_desc(32'h188, 16'h8800, 16'd4, 32'h200);
        clear_logs();
        run_and_compare("R4 non-ready stops");
        chk(32'(n_wr), 32'd0, "R4 no writeback for non-ready");
        chk(32'(n_txb + n_txf + n_babt), 32'd0, "R4 no events for non-ready");
        chk(32'(n_req), 32'd1, "R2 pointer reset to new base, single header read");
    endtask

    task automatic t_cap();
        reg_write(1'b0, 32'h40);
        set_desc(32'h40, 16'h8000, 16'd10, 32'h240);
        set_desc(32'h48, 16'h8800, 16'd10, 32'h260);
        set_desc(32'h50, 16'hA800, 16'd3, 32'h280);
        clear_logs();
        add_exp(32'h240, 10); add_exp(32'h260, 6); add_eof();
        add_exp(32'h280, 3); add_eof();
        run_and_compare("R9 frame capped then count restarts");
        chk(32'(n_babt), 32'd1, "R9 one babble event");
        chk(mem[32'h48 >> 2], 32'h0800_000A, "R9 capped descriptor keeps length");
        chk(32'(n_txf), 32'd2, "R7 two frames completed");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            logic [31:0] a;
            a = 32'(i) << 2;
            mem[i] = (i < 128) ? 32'd0 : {pat(a), pat(a + 1), pat(a + 2), pat(a + 3)};
        end
        t_reset();
        t_regs();
        t_single();
        t_multi_bp();
        t_not_ready();
        t_cap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule